// File: doc/BRIEF.md
# Amplifier Fault Auto-Restore Controller

This block drives the active-high protection enable of a power output stage. When the fault input rises, the enable drops in the same cycle. The block then waits a programmable number of millisecond ticks and releases the stage again. It counts every automatic release. If the count reaches a programmable threshold inside a restore window, the block stops recovering and keeps the enable low until software issues a clear strobe. The window length is the product of three configuration fields: hold length, threshold and window multiplier. The defaults of 4, 5 and 2 give a 40 ms window.

The controller is a four-state machine:

| State | Enable | Meaning |
|-------|--------|---------|
| `ST_START` | low | Uncounted startup hold, entered from reset or after a clear |
| `ST_RUN` | high unless fault is present | Normal operation |
| `ST_HOLD` | low | Counted hold time after a fault |
| `ST_LATCH` | low | Permanent shutdown |

The transitions are:

| Transition | From | To | Condition |
|------------|------|----|-----------|
| start-done | `ST_START` | `ST_RUN` | The hold time expires |
| trip | `ST_RUN` | `ST_HOLD` | The fault input is high |
| restore | `ST_HOLD` | `ST_RUN` | The hold time expires and the count is still below the threshold |
| lockout | `ST_HOLD` | `ST_LATCH` | The hold time expires and the count reaches the threshold |
| unlock | `ST_LATCH` | `ST_START` | The clear strobe is high |

A manual override replaces the enable output with a software value. The state machine keeps running underneath it.

Top module: `fault_restore_ctrl`

## Requirements
- R1: After reset, `protect_o` is 0 and `latched_o` is 0. The block is in `ST_START`. Once `cfg_hold` ticks have been seen with no fault, `protect_o` becomes 1 in the cycle after the clock edge that samples the last tick. This startup release is not counted.
- R2: While `fault_i` is 1 and manual mode is off, `protect_o` is 0 in the same cycle. A fault seen in `ST_RUN` enters `ST_HOLD`. `protect_o` stays 0 until `cfg_hold` ticks have been sampled after the fault, then returns to 1.
- R3: A fault sampled during a hold restarts the tick count from zero.
- R4: Each restore adds 1 to the restore counter. When a restore would bring the counter to `cfg_limit`, the block takes the lockout transition instead. It then holds `protect_o` at 0 and `latched_o` at 1, and faults have no effect.
- R5: The window length is `cfg_hold` × `cfg_limit` × `cfg_mult` ticks. The window starts at the restore that takes the counter from 0 to 1. When that many ticks have passed, the counter returns to 0.
- R6: `clear_i` sets the counter to 0. In `ST_LATCH`, it also drops `latched_o` at the next edge and enters `ST_START`, so `protect_o` returns to 1 after `cfg_hold` ticks.
- R7: While `manual_en_i` is 1, `protect_o` equals `manual_val_i`, including during a fault. The state machine keeps advancing while the override is on.
- R8: A configuration field of value 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_i | input | 1 | Fault indication from the power stage |
| tick_i | input | 1 | One-cycle millisecond tick |
| cfg_hold | input | HOLD_W | Hold length in ticks |
| cfg_limit | input | LIMIT_W | Number of restores that triggers lockout |
| cfg_mult | input | MULT_W | Window multiplier |
| clear_i | input | 1 | Clears the counter and releases lockout |
| manual_en_i | input | 1 | Manual override enable |
| manual_val_i | input | 1 | Enable value driven while the override is on |
| protect_o | output | 1 | Power stage enable, active high |
| latched_o | output | 1 | Permanent lockout flag |

## Verification
A wrong restore count or a window that does not restart shows at the ports only at the next restore. There, the lockout transition comes one fault too early or too late. The bench therefore packs several faults into short and long windows, so that a count left over from an earlier window shows within a few ticks. A wrong hold count shows as `protect_o` rising on the wrong tick. A reference model that checks every cycle catches it in the cycle where it happens.

// File: rtl/frp_pkg.sv
package frp_pkg;
    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_RUN   = 2'd1,
        ST_HOLD  = 2'd2,
        ST_LATCH = 2'd3
    } frp_state_e;
endpackage

// File: rtl/frp_hold_timer.sv
module frp_hold_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    input  logic         tick,
    input  logic [W-1:0] len,
    output logic         done
);
    logic [W-1:0] cnt_q;
    logic [W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign done    = run && tick && !restart && (cnt_inc >= {1'b0, len});

    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            cnt_q <= '0;
        end else if (tick && !done) begin
            cnt_q <= cnt_inc[W-1:0];
        end
    end

    // R3: a fault during the hold restarts the count
    assert_hold_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && restart) |=> (cnt_q == '0));
endmodule

// File: rtl/frp_window.sv
module frp_window #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         start,
    input  logic         tick,
    input  logic [W-1:0] interval,
    output logic         expire
);
    logic [W-1:0] win_q;
    logic [W:0]   win_inc;

    assign win_inc = {1'b0, win_q} + 1'b1;
    assign expire  = active && tick && (win_inc >= {1'b0, interval});

    always_ff @(posedge clk) begin
        if (!rst_n || start || expire || !active) begin
            win_q <= '0;
        end else if (tick) begin
            win_q <= win_inc[W-1:0];
        end
    end

    // R5: the window counter never runs past its length
    assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $stable(interval) && interval != '0) |-> (win_q < interval));
endmodule

// File: rtl/frp_restore_cnt.sv
module frp_restore_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         restore,
    input  logic         expire,
    input  logic [W-1:0] limit,
    output logic         reach,
    output logic         fresh,
    output logic         empty
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] base;
    logic [W:0]   base_inc;

    assign base     = expire ? '0 : cnt_q;
    assign base_inc = {1'b0, base} + 1'b1;
    assign fresh    = (base == '0);
    assign empty    = (cnt_q == '0);
    assign reach    = !clear && restore && (base_inc >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (restore) begin
            cnt_q <= base_inc[W-1:0];
        end else begin
            cnt_q <= base;
        end
    end

    // R6: a clear empties the counter
    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> empty);
    // R5: an expired window with no restore leaves the counter empty
    assert_expire_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !restore) |=> empty);
endmodule

// File: rtl/fault_restore_ctrl.sv
module fault_restore_ctrl
    import frp_pkg::*;
#(
    parameter int HOLD_W  = 4,
    parameter int LIMIT_W = 4,
    parameter int MULT_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fault_i,
    input  logic               tick_i,
    input  logic [HOLD_W-1:0]  cfg_hold,
    input  logic [LIMIT_W-1:0] cfg_limit,
    input  logic [MULT_W-1:0]  cfg_mult,
    input  logic               clear_i,
    input  logic               manual_en_i,
    input  logic               manual_val_i,
    output logic               protect_o,
    output logic               latched_o
);
    localparam int WIN_W = HOLD_W + LIMIT_W + MULT_W;

    frp_state_e state_q, state_d;

    logic [HOLD_W-1:0]  hold_eff;
    logic [LIMIT_W-1:0] limit_eff;
    logic [MULT_W-1:0]  mult_eff;
    logic [WIN_W-1:0]   interval;
    logic timing_run, hold_done, restore, reach, fresh, empty, expire, win_active;
    logic auto_prot;

    assign hold_eff  = (cfg_hold  == '0) ? HOLD_W'(1)  : cfg_hold;
    assign limit_eff = (cfg_limit == '0) ? LIMIT_W'(1) : cfg_limit;
    assign mult_eff  = (cfg_mult  == '0) ? MULT_W'(1)  : cfg_mult;
    assign interval  = WIN_W'(hold_eff) * WIN_W'(limit_eff) * WIN_W'(mult_eff);

    assign timing_run = (state_q == ST_START) || (state_q == ST_HOLD);
    assign restore    = (state_q == ST_HOLD) && hold_done;
    assign win_active = !empty && (state_q != ST_LATCH);

    frp_hold_timer #(.W(HOLD_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .run(timing_run), .restart(fault_i),
        .tick(tick_i), .len(hold_eff), .done(hold_done)
    );

    frp_window #(.W(WIN_W)) u_window (
        .clk(clk), .rst_n(rst_n), .active(win_active), .start(restore && fresh),
        .tick(tick_i), .interval(interval), .expire(expire)
    );

    frp_restore_cnt #(.W(LIMIT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .clear(clear_i), .restore(restore),
        .expire(expire), .limit(limit_eff), .reach(reach), .fresh(fresh),
        .empty(empty)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_START: if (hold_done) state_d = ST_RUN;
            ST_RUN:   if (fault_i)   state_d = ST_HOLD;
            ST_HOLD:  if (hold_done) state_d = reach ? ST_LATCH : ST_RUN;
            ST_LATCH: if (clear_i)   state_d = ST_START;
            default:                 state_d = ST_START;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_START;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        auto_prot = (state_q == ST_RUN) && !fault_i;
        latched_o = (state_q == ST_LATCH);
        protect_o = manual_en_i ? manual_val_i : auto_prot;
    end

    // R2: a fault forces the enable low in the same cycle
    assert_fault_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_i && !manual_en_i) |-> !protect_o);
    // R4: lockout keeps the enable low
    assert_latch_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_o && !manual_en_i) |-> !protect_o);
    // R4: lockout persists until a clear
    assert_latch_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_o && !clear_i) |=> latched_o);
    // R6: a clear always leaves lockout
    assert_clear_unlocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !latched_o);
endmodule

// File: tb/tb_fault_restore_ctrl.sv
module tb_fault_restore_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fault_i = 1'b0, tick_i = 1'b0, clear_i = 1'b0;
    logic manual_en_i = 1'b0, manual_val_i = 1'b0;
    logic [3:0] cfg_hold = 4'd4, cfg_limit = 4'd5, cfg_mult = 4'd2;
    logic protect_o, latched_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    string phase = "R1";

    // reference model state: 0 startup, 1 running, 2 holding, 3 locked
    int m_state = 0, m_hold = 0, m_cnt = 0, m_win = 0;

    always #4 clk = ~clk;

    fault_restore_ctrl dut (
        .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .tick_i(tick_i),
        .cfg_hold(cfg_hold), .cfg_limit(cfg_limit), .cfg_mult(cfg_mult),
        .clear_i(clear_i), .manual_en_i(manual_en_i), .manual_val_i(manual_val_i),
        .protect_o(protect_o), .latched_o(latched_o)
    );

    always @(posedge clk) begin
        int h, l, m, iv, base;
        bit act, expd, timing, done, rel, reach;
        if (!rst_n) begin
            m_state = 0; m_hold = 0; m_cnt = 0; m_win = 0;
        end else begin
            h  = (cfg_hold  == 0) ? 1 : int'(cfg_hold);
            l  = (cfg_limit == 0) ? 1 : int'(cfg_limit);
            m  = (cfg_mult  == 0) ? 1 : int'(cfg_mult);
            iv = h * l * m;
            act    = (m_cnt > 0) && (m_state != 3);
            expd   = act && tick_i && (m_win + 1 >= iv);
            base   = expd ? 0 : m_cnt;
            timing = (m_state == 0) || (m_state == 2);
            done   = timing && tick_i && !fault_i && (m_hold + 1 >= h);
            rel    = (m_state == 2) && done;
            reach  = !clear_i && rel && (base + 1 >= l);
            if (!timing || fault_i) m_hold = 0;
            else if (tick_i && !done) m_hold = m_hold + 1;
            if ((rel && base == 0) || expd || !act) m_win = 0;
            else if (tick_i) m_win = m_win + 1;
            if (clear_i) m_cnt = 0;
            else if (rel) m_cnt = base + 1;
            else m_cnt = base;
            case (m_state)
                0: if (done) m_state = 1;
                1: if (fault_i) m_state = 2;
                2: if (done) m_state = reach ? 3 : 1;
                default: if (clear_i) m_state = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        bit ep, el;
        if (rst_n) begin
            el = (m_state == 3);
            ep = manual_en_i ? manual_val_i : ((m_state == 1) && !fault_i);
            checks++;
            if (protect_o !== ep || latched_o !== el) begin
                fails++;
                $display("FAIL %s model compare: protect=%0b latched=%0b expected protect=%0b latched=%0b",
                         phase, protect_o, latched_o, ep, el);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1; cyc();
            tick_i = 1'b0; cyc();
        end
    endtask

    task automatic expect_out(input bit ep, input bit el, input string tag);
        @(negedge clk);
        checks++;
        if (protect_o !== ep || latched_o !== el) begin
            fails++;
            $display("FAIL %s: protect=%0b latched=%0b expected protect=%0b latched=%0b",
                     tag, protect_o, latched_o, ep, el);
        end
    endtask

    task automatic fault_pulse(input string tag);
        fault_i = 1'b1;
        expect_out(1'b0, latched_o, tag);
        cyc();
        fault_i = 1'b0;
    endtask

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        phase = "R1";
        expect_out(1'b0, 1'b0, "R1 reset state");
        ticks(3); expect_out(1'b0, 1'b0, "R1 startup hold");
        ticks(1); expect_out(1'b1, 1'b0, "R1 startup release");

        phase = "R2";
        fault_pulse("R2 immediate low");
        ticks(3); expect_out(1'b0, 1'b0, "R2 still holding");
        ticks(1); expect_out(1'b1, 1'b0, "R2 restored");

        phase = "R3";
        fault_pulse("R3 first fault");
        ticks(2);
        fault_pulse("R3 refault");
        ticks(3); expect_out(1'b0, 1'b0, "R3 restart");
        ticks(1); expect_out(1'b1, 1'b0, "R3 restored");

        phase = "R5";
        ticks(40);
        for (int k = 1; k <= 5; k++) begin
            fault_pulse("R4 fault burst");
            ticks(4);
            if (k == 3) expect_out(1'b1, 1'b0, "R5 window expiry cleared count");
        end
        phase = "R4";
        expect_out(1'b0, 1'b1, "R4 lockout at threshold");

        phase = "R6";
        fault_pulse("R4 fault in lockout");
        ticks(10); expect_out(1'b0, 1'b1, "R6 lockout persists");
        clear_i = 1'b1; cyc(); clear_i = 1'b0;
        expect_out(1'b0, 1'b0, "R6 clear unlocks");
        ticks(3); expect_out(1'b0, 1'b0, "R6 startup hold");
        ticks(1); expect_out(1'b1, 1'b0, "R6 restored");

        phase = "R7";
        manual_en_i = 1'b1; manual_val_i = 1'b0; cyc();
        expect_out(1'b0, 1'b0, "R7 manual low");
        manual_val_i = 1'b1; fault_i = 1'b1; cyc();
        expect_out(1'b1, 1'b0, "R7 manual high over fault");
        fault_i = 1'b0; manual_en_i = 1'b0;
        expect_out(1'b0, 1'b0, "R7 auto hold continued");
        ticks(4); expect_out(1'b1, 1'b0, "R7 auto restored");

        phase = "R8";
        cfg_limit = 4'd0;
        fault_pulse("R8 fault");
        ticks(4); expect_out(1'b0, 1'b1, "R8 zero threshold locks");
        cfg_limit = 4'd5; cfg_hold = 4'd0;
        clear_i = 1'b1; cyc(); clear_i = 1'b0;
        ticks(1); expect_out(1'b1, 1'b0, "R8 zero hold is one tick");

        phase = "R5";
        cfg_hold = 4'd1; cfg_limit = 4'd2; cfg_mult = 4'd1;
        clear_i = 1'b1; cyc(); clear_i = 1'b0;
        fault_pulse("R5 short window fault");
        ticks(1);
        ticks(2);
        fault_pulse("R5 after expiry");
        ticks(1); expect_out(1'b1, 1'b0, "R5 short window expired");
        fault_pulse("R4 quick refault");
        ticks(1); expect_out(1'b0, 1'b1, "R4 two restores in window");

        cyc(); cyc();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule